// File: doc/BRIEF.md
# Cache Burst Read Timing Sequencer

This block paces a four-beat burst read hit from an external second-level cache SRAM. The request carries one start address. The sequencer holds the SRAM output enable for the whole burst and steps the word address through the other three beats by itself. It raises a one-clock ready strobe to the CPU at the end of each beat. A two-bit pattern code sets the timing. It picks how many clocks the first beat takes and how many each later beat takes. A single-bank strap overrides the code with a slower uniform pace.

A request is accepted only while the sequencer is idle. At that moment it captures the start address, the pattern and the strap. The burst then runs to its end without regard to any new input. A done strobe marks the final word so that the caller can start the next burst.

Top module: `cache_burst_seq`

## Requirements
- R1: Every accepted burst produces exactly four `beat_rdy` pulses. Each pulse lasts one clock.
- R2: Beats are numbered n = 0..3. During beat n, `sram_addr` equals the captured start address with bits [3:2] XORed with n. All other bits are passed through unchanged, so beat 0 presents the start address itself.
- R3: `timing_sel` selects the clocks per beat: 0 gives 2-1-1-1, 1 gives 3-1-1-1, 2 gives 2-2-2-2 and 3 gives 3-2-2-2. The clock after the accepting edge is clock 1. `beat_rdy` is high in the last clock of each beat.
- R4: A burst lasts 5 clocks with code 0, 6 with code 1, 8 with code 2 and 9 with code 3, counted from clock 1 through the fourth ready.
- R5: When `single_bank` is 1 at acceptance, every beat takes 2 clocks, whatever the code.
- R6: `burst_done` is high only in the clock of the fourth `beat_rdy`.
- R7: A `burst_req` seen while a burst is running, including in its final clock, is ignored. If the request is held high, `sram_oe` is low for exactly one clock between two bursts.
- R8: `sram_oe` is high from clock 1 through the fourth ready clock and low otherwise. `sram_addr` does not change within a beat.
- R9: Changes to `start_addr`, `timing_sel` or `single_bank` after acceptance have no effect on the running burst.
- R10: While reset is held, `sram_oe`, `beat_rdy` and `burst_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_req | input | 1 | Start a burst read hit (taken when idle) |
| start_addr | input | ADDR_W | Address of the first word |
| timing_sel | input | 2 | Beat timing pattern code |
| single_bank | input | 1 | Only one cache bank fitted; forces 2 clocks per beat |
| sram_addr | output | ADDR_W | Word address to the cache SRAM |
| sram_oe | output | 1 | SRAM output enable, high for the whole burst |
| beat_rdy | output | 1 | One-clock ready per delivered word |
| burst_done | output | 1 | Marks the fourth word of the burst |

## Verification
The bench builds the block with its default latencies: 2 or 3 clocks for the first beat, 1 or 2 clocks for later beats, and 2 clocks under the single-bank strap. It uses a 32-bit address. These values reach all four pattern codes, each with and without the strap. They also reach back-to-back consecutive ready clocks in the fast patterns and every wrap order of address bits [3:2]. A request held across the final clock checks both the one-clock gap and that a request inside a running burst is dropped.

// File: rtl/cache_burst_seq_pkg.sv
package cache_burst_seq_pkg;

    // Beat timing pattern codes (first beat - later beats)
    typedef enum logic [1:0] {
        PAT_2111 = 2'd0,
        PAT_3111 = 2'd1,
        PAT_2222 = 2'd2,
        PAT_3222 = 2'd3
    } burst_pat_e;

    localparam int unsigned BURST_BEATS = 4;

    function automatic int unsigned lat_bits(input int unsigned a, input int unsigned b,
                                             input int unsigned c, input int unsigned d,
                                             input int unsigned e);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/bst_pattern_dec.sv
module bst_pattern_dec
    import cache_burst_seq_pkg::*;
#(
    parameter int unsigned LAT_W      = 2,
    parameter int unsigned FIRST_FAST = 2,
    parameter int unsigned FIRST_SLOW = 3,
    parameter int unsigned NEXT_FAST  = 1,
    parameter int unsigned NEXT_SLOW  = 2,
    parameter int unsigned BANK_LAT   = 2
) (
    input  logic [1:0]       sel,
    input  logic             single_bank,
    output logic [LAT_W-1:0] first_lat,
    output logic [LAT_W-1:0] next_lat
);
    burst_pat_e pat;

    always_comb begin
        pat = burst_pat_e'(sel);
        if (single_bank) begin
            first_lat = LAT_W'(BANK_LAT);
            next_lat  = LAT_W'(BANK_LAT);
        end else begin
            unique case (pat)
                PAT_2111: begin first_lat = LAT_W'(FIRST_FAST); next_lat = LAT_W'(NEXT_FAST); end
                PAT_3111: begin first_lat = LAT_W'(FIRST_SLOW); next_lat = LAT_W'(NEXT_FAST); end
                PAT_2222: begin first_lat = LAT_W'(FIRST_FAST); next_lat = LAT_W'(NEXT_SLOW); end
                default:  begin first_lat = LAT_W'(FIRST_SLOW); next_lat = LAT_W'(NEXT_SLOW); end
            endcase
        end
    end
endmodule

// File: rtl/bst_addr_gen.sv
module bst_addr_gen #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned BEAT_W   = 2,
    parameter int unsigned LANE_LSB = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    output logic [ADDR_W-1:0] addr
);
    for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
        if (g >= LANE_LSB && g < LANE_LSB + BEAT_W) begin : g_lane
            assign addr[g] = base[g] ^ beat[g - LANE_LSB];
        end else begin : g_pass
            assign addr[g] = base[g];
        end
    end
endmodule

// File: rtl/bst_seq_core.sv
module bst_seq_core #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LAT_W  = 2,
    parameter int unsigned BEATS  = 4,
    localparam int unsigned BEAT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LAT_W-1:0]  first_lat,
    input  logic [LAT_W-1:0]  next_lat,
    output logic              busy,
    output logic [BEAT_W-1:0] beat,
    output logic [ADDR_W-1:0] base,
    output logic              rdy,
    output logic              done
);
    typedef struct packed {
        logic              busy;
        logic [BEAT_W-1:0] beat;
        logic [LAT_W-1:0]  cnt;
        logic [LAT_W-1:0]  next_lat;
        logic [ADDR_W-1:0] base;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    rdy_d;
    logic    last_beat;

    always_comb begin
        st_d      = st_q;
        rdy_d     = st_q.busy && (st_q.cnt == LAT_W'(1));
        last_beat = (st_q.beat == BEAT_W'(BEATS - 1));
        if (!st_q.busy) begin
            if (req) begin
                st_d.busy     = 1'b1;
                st_d.beat     = '0;
                st_d.cnt      = first_lat;
                st_d.next_lat = next_lat;
                st_d.base     = start_addr;
            end
        end else if (rdy_d) begin
            if (last_beat) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.beat = st_q.beat + BEAT_W'(1);
                st_d.cnt  = st_q.next_lat;
            end
        end else begin
            st_d.cnt = st_q.cnt - LAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign beat = st_q.beat;
    assign base = st_q.base;
    assign rdy  = rdy_d;
    assign done = rdy_d && last_beat;
endmodule

// File: rtl/cache_burst_seq.sv
module cache_burst_seq
    import cache_burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned FIRST_FAST = 2,
    parameter int unsigned FIRST_SLOW = 3,
    parameter int unsigned NEXT_FAST  = 1,
    parameter int unsigned NEXT_SLOW  = 2,
    parameter int unsigned BANK_LAT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        timing_sel,
    input  logic              single_bank,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_oe,
    output logic              beat_rdy,
    output logic              burst_done
);
    localparam int unsigned LAT_W  = lat_bits(FIRST_FAST, FIRST_SLOW, NEXT_FAST, NEXT_SLOW, BANK_LAT);
    localparam int unsigned BEAT_W = $clog2(BURST_BEATS);

    logic [LAT_W-1:0]  first_lat, next_lat;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base;

    bst_pattern_dec #(
        .LAT_W(LAT_W), .FIRST_FAST(FIRST_FAST), .FIRST_SLOW(FIRST_SLOW),
        .NEXT_FAST(NEXT_FAST), .NEXT_SLOW(NEXT_SLOW), .BANK_LAT(BANK_LAT)
    ) u_dec (
        .sel(timing_sel), .single_bank(single_bank),
        .first_lat(first_lat), .next_lat(next_lat)
    );

    bst_seq_core #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .BEATS(BURST_BEATS)) u_core (
        .clk(clk), .rst_n(rst_n), .req(burst_req), .start_addr(start_addr),
        .first_lat(first_lat), .next_lat(next_lat),
        .busy(sram_oe), .beat(beat), .base(base), .rdy(beat_rdy), .done(burst_done)
    );

    bst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .LANE_LSB(2)) u_addr (
        .base(base), .beat(beat), .addr(sram_addr)
    );
endmodule

// File: rtl/cache_burst_seq_chk.sv
module cache_burst_seq_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              burst_req,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_oe,
    input logic              beat_rdy,
    input logic              burst_done
);
    logic [2:0] rdy_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          rdy_cnt_q <= '0;
        else if (burst_done) rdy_cnt_q <= '0;
        else if (beat_rdy)   rdy_cnt_q <= rdy_cnt_q + 3'd1;
    end

    a_r1_four_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> rdy_cnt_q == 3'd3);
    a_r6_done_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> beat_rdy);
    a_r8_rdy_inside_oe: assert property (@(posedge clk) disable iff (!rst_n)
        beat_rdy |-> sram_oe);
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_oe && !beat_rdy) |=> $stable(sram_addr));
    a_r7_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_oe && !burst_done) |=> sram_oe);
    a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !sram_oe);
    a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe && burst_req) |=> (sram_oe && sram_addr == $past(start_addr)));
endmodule

bind cache_burst_seq cache_burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .start_addr(start_addr),
    .sram_addr(sram_addr), .sram_oe(sram_oe), .beat_rdy(beat_rdy), .burst_done(burst_done)
);

// File: tb/cache_burst_seq_test.sv
`timescale 1ns/1ps
module cache_burst_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        burst_req = 1'b0;
    logic [31:0] start_addr = '0;
    logic [1:0]  timing_sel = '0;
    logic        single_bank = 1'b0;
    logic [31:0] sram_addr;
    logic        sram_oe, beat_rdy, burst_done;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    cache_burst_seq uut (
        .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .start_addr(start_addr),
        .timing_sel(timing_sel), .single_bank(single_bank), .sram_addr(sram_addr),
        .sram_oe(sram_oe), .beat_rdy(beat_rdy), .burst_done(burst_done)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic        sb;
        logic [31:0] addr;
        logic [3:0]  l1;
        logic [3:0]  ln;
    } vec_t;

    // expected latencies from R3 and R5
    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b0, 32'h0000_1000, 4'd2, 4'd1},
        '{2'd1, 1'b0, 32'h0000_2006, 4'd3, 4'd1},
        '{2'd2, 1'b0, 32'hA5A5_5A09, 4'd2, 4'd2},
        '{2'd3, 1'b0, 32'hFFFF_FFFF, 4'd3, 4'd2},
        '{2'd0, 1'b1, 32'h1234_5674, 4'd2, 4'd2},
        '{2'd1, 1'b1, 32'h0000_0008, 4'd2, 4'd2},
        '{2'd2, 1'b1, 32'h8000_000C, 4'd2, 4'd2},
        '{2'd3, 1'b1, 32'h0F0F_0F03, 4'd2, 4'd2}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // disturb=1: raise a new request with other inputs from clock 2 until after the final clock (R7, R9)
    task automatic run_burst(input logic [1:0] sel, input logic sb, input logic [31:0] a,
                             input int l1, input int ln, input bit disturb);
        int n = 0;
        int due = l1;
        int total = l1 + 3 * ln;
        @(negedge clk);
        timing_sel = sel; single_bank = sb; start_addr = a; burst_req = 1'b1;
        @(negedge clk);
        burst_req = 1'b0;
        for (int c = 1; c <= total + 1; c++) begin
            bit exp_rdy;
            if (c > 1) @(negedge clk);
            exp_rdy = (n < 4) && (c == due);
            chk(beat_rdy == exp_rdy, "R3 ready timing", 32'(beat_rdy), 32'(exp_rdy));
            chk(sram_oe == (n < 4), "R8 output enable", 32'(sram_oe), 32'(n < 4));
            if (exp_rdy) begin
                chk(sram_addr == (a ^ (32'(n) << 2)), "R2 beat address", sram_addr, a ^ (32'(n) << 2));
                chk(burst_done == (n == 3), "R6 done on fourth ready", 32'(burst_done), 32'(n == 3));
                if (n == 3) chk(c == total, "R4 burst length", 32'(c), 32'(total));
                n++;
                due += ln;
            end else begin
                chk(burst_done == 1'b0, "R6 done only with ready", 32'(burst_done), 32'd0);
            end
            if (disturb && c == 1) begin
                burst_req = 1'b1; start_addr = ~a; timing_sel = ~sel; single_bank = ~sb;
            end
            if (disturb && c == total + 1) burst_req = 1'b0;
        end
        chk(n == 4, "R1 four ready pulses", 32'(n), 32'd4);
        if (disturb) begin
            @(negedge clk);
            chk(sram_oe == 1'b0, "R7 request in busy or final clock dropped", 32'(sram_oe), 32'd0);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        burst_req = 1'b1;   // request during reset must not start anything
        repeat (3) @(negedge clk);
        chk(sram_oe == 1'b0,    "R10 reset oe",    32'(sram_oe), 32'd0);
        chk(beat_rdy == 1'b0,   "R10 reset ready", 32'(beat_rdy), 32'd0);
        chk(burst_done == 1'b0, "R10 reset done",  32'(burst_done), 32'd0);
        burst_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(sram_oe == 1'b0, "R10 idle after reset", 32'(sram_oe), 32'd0);

        // table walk: R3, R4, R5, R2
        foreach (VECS[i]) begin
            run_burst(VECS[i].sel, VECS[i].sb, VECS[i].addr, int'(VECS[i].l1), int'(VECS[i].ln), 1'b0);
        end

        // R7 / R9: inputs change and request is raised while busy
        run_burst(2'd0, 1'b0, 32'h0000_0104, 2, 1, 1'b1);
        run_burst(2'd3, 1'b0, 32'h0000_0F08, 3, 2, 1'b1);

        // R7: request held high across bursts gives a one-clock gap
        @(negedge clk);
        timing_sel = 2'd0; single_bank = 1'b0; start_addr = 32'h0000_4000; burst_req = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (burst_done) break;
        end
        start_addr = 32'h0000_500C;
        @(negedge clk);
        chk(sram_oe == 1'b0, "R7 one-clock gap", 32'(sram_oe), 32'd0);
        @(negedge clk);
        chk(sram_oe == 1'b1, "R7 held request restarts", 32'(sram_oe), 32'd1);
        chk(sram_addr == 32'h0000_500C, "R2 restart address", sram_addr, 32'h0000_500C);
        burst_req = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (burst_done) break;
        end
        @(negedge clk);
        chk(sram_oe == 1'b0, "R8 idle after burst", 32'(sram_oe), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule